// File: doc/BRIEF.md
# Banked Multi-Buffer Scratchpad

This block is a local memory that feeds a vector datapath. It takes one vector of lane addresses for writing and one for reading in each cycle. The storage is spread over several banks, so a group of consecutive addresses can be written together. A decode setting chooses how an address is split into a bank number and a word offset within that bank. A read may place every lane on any word, including the same word. The storage acts as though each read lane had its own copy of the data.

A mode input selects one of three uses. In scratchpad mode, lane addresses go straight to the decoder. In queue mode, the memory becomes a first-in first-out store of whole vectors, with full and empty flags and backpressure on both ports. In rotating-buffer mode, the space is split into N equal buffers. A producer writes one buffer while a consumer reads the buffer the producer filled before it. The two buffers move on together once the producer and the consumer have each signalled completion of the current phase.

When more than one lane of a write targets the same bank, the write is spread over several cycles. Lanes are committed in ascending lane order, and the requester holds its vector until `wr_ready` is asserted.

Top module: `spm_unit`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, `rd_data_valid` is 0 and `swap_pulse` is 0.
- R2: With `cfg_blocked`=0, bank = address mod BANKS and offset = address / BANKS. A write whose enabled lanes fall in distinct banks completes in the cycle it is presented, with `wr_ready` high in that same cycle.
- R3: With `cfg_blocked`=1, bank = address / BANK_DEPTH and offset = address mod BANK_DEPTH. A write needs as many cycles as the largest number of enabled lanes that share one bank. `wr_ready` is high only in the final cycle.
- R4: Lanes of one write are committed in ascending lane order. When several lanes name the same word, the highest such lane's data remains.
- R5: An accepted read (`rd_valid` and `rd_ready`) returns data for every lane one cycle later, with `rd_data_valid` high in that cycle only. Any number of lanes may read the same word. `rd_ready` is always 1 outside queue mode.
- R6: A lane whose `wr_mask` bit is 0 writes nothing. A write with an all-zero mask completes in one cycle.
- R7: With `cfg_mode`=1 (queue), each push stores the full vector and each pop returns vectors in push order. `wr_mask`, `wr_addr`, `rd_addr` and `cfg_blocked` are ignored in this mode.
- R8: The queue holds BANKS*BANK_DEPTH/LANES vectors. When full, `wr_ready` is 0 and a presented push changes nothing. When empty, `rd_ready` is 0 and no data is returned. Leaving queue mode empties the queue.
- R9: With `cfg_mode`=2 (rotating), a write to in-buffer address a lands at word phase*BUF_WORDS + a. A read of address a comes from word ((phase-1) mod N)*BUF_WORDS + a. The phase is 0 on entering the mode.
- R10: The phase advances only at a clock edge where `prod_done` and `cons_done` have both been seen since the last advance, in either order or in the same cycle. `swap_pulse` is high for exactly the cycle after that edge.
- R11: The phase wraps from N-1 back to 0.
- R12: A read of a word written in the same cycle returns the word's previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0 scratchpad, 1 queue, 2 rotating buffers, 3 as scratchpad |
| cfg_blocked | input | 1 | 0 interleaved decode, 1 blocked decode |
| wr_valid | input | 1 | Write vector presented |
| wr_mask | input | LANES | Per-lane write enable |
| wr_addr | input | LANES*AW | Per-lane write address |
| wr_data | input | LANES*DW | Per-lane write data |
| wr_ready | output | 1 | Write vector completes this cycle |
| rd_valid | input | 1 | Read vector presented |
| rd_addr | input | LANES*AW | Per-lane read address |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_data | output | LANES*DW | Read data, one cycle after acceptance |
| rd_data_valid | output | 1 | `rd_data` carries a new result |
| prod_done | input | 1 | Producer finished the current phase |
| cons_done | input | 1 | Consumer finished the current phase |
| swap_pulse | output | 1 | Buffers rotated at the last edge |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |

## Verification
The assertions rely on a few rules for the inputs. Outside queue mode, a write held back by a bank clash stays presented with the same vector until `wr_ready` rises. `cfg_mode` changes only when no transfer is in progress. Addresses used in rotating mode stay below BUF_WORDS. The stimulus follows these rules. Every write is issued by one task that holds the vector until it completes. Mode changes are made between tasks, with an idle cycle around each. Rotating-mode addresses are chosen inside one buffer. The only deliberate break is a single-cycle push against a full queue, and the hold check is scoped out of queue mode for that case.

// File: rtl/spm_pkg.sv
// Shared types for the banked scratchpad unit.
package spm_pkg;
    typedef enum logic [1:0] {
        MODE_BANKED = 2'd0,
        MODE_FIFO   = 2'd1,
        MODE_NBUF   = 2'd2,
        MODE_RSVD   = 2'd3
    } spm_mode_e;
endpackage

// File: rtl/spm_addr_decode.sv
// Splits one word address into a bank number and an offset in that bank.
// Assumes BANKS and BANK_DEPTH are powers of two, both at least 2.
module spm_addr_decode #(
    parameter int BANKS      = 4,
    parameter int BANK_DEPTH = 16,
    localparam int BB = $clog2(BANKS),
    localparam int OW = $clog2(BANK_DEPTH),
    localparam int AW = BB + OW
) (
    input  logic [AW-1:0] addr,
    input  logic          blocked,
    output logic [BB-1:0] bank,
    output logic [OW-1:0] offset
);
    // Interleaved: low bits pick the bank; blocked: high bits pick it.
    always_comb begin
        if (blocked) begin
            bank   = addr[AW-1:OW];
            offset = addr[OW-1:0];
        end else begin
            bank   = addr[BB-1:0];
            offset = addr[AW-1:BB];
        end
    end
endmodule

// File: rtl/spm_write_sched.sv
// Picks the lanes that may write this cycle: a pending lane is granted
// when no lower pending lane targets the same bank. Assumes the caller
// removes granted lanes from the pending set for the next cycle.
module spm_write_sched #(
    parameter int LANES = 4,
    parameter int BB    = 2
) (
    input  logic [LANES-1:0]         pending,
    input  logic [LANES-1:0][BB-1:0] bank,
    output logic [LANES-1:0]         grant,
    output logic                     last
);
    // Lane-order priority: the lowest lane on each bank wins.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            grant[i] = pending[i];
            for (int j = 0; j < LANES; j++) begin
                if (j < i && pending[j] && bank[j] == bank[i]) begin
                    grant[i] = 1'b0;
                end
            end
        end
        last = (grant == pending);
    end
endmodule

// File: rtl/spm_fifo_ctrl.sv
// Vector-granular queue pointers and occupancy. Push and pop arrive
// already gated by full and empty. Assumes DEPTH is a power of two.
// Everything clears while disabled.
module spm_fifo_ctrl #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          full,
    output logic          empty
);
    logic [CW-1:0] count;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Status flags from occupancy.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end
endmodule

// File: rtl/spm_nbuf_ctrl.sv
// Rotating-buffer phase. Remembers producer and consumer completion, and
// advances the phase modulo NBUF once both are seen. Assumes NBUF >= 2.
// Everything clears while disabled.
module spm_nbuf_ctrl #(
    parameter int NBUF = 2,
    localparam int PW = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          prod_done,
    input  logic          cons_done,
    output logic [PW-1:0] wr_sel,
    output logic [PW-1:0] rd_sel,
    output logic          swap_pulse
);
    logic [PW-1:0] phase;
    logic prod_seen, cons_seen, prod_hit, cons_hit, do_swap;

    // Completion seen this phase, including the current cycle.
    always_comb begin
        prod_hit = prod_seen | prod_done;
        cons_hit = cons_seen | cons_done;
        do_swap  = enable & prod_hit & cons_hit;
    end

    // Phase, sticky completion flags and swap indication.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase      <= '0;
            prod_seen  <= 1'b0;
            cons_seen  <= 1'b0;
            swap_pulse <= 1'b0;
        end else begin
            swap_pulse <= do_swap;
            prod_seen  <= prod_hit & ~do_swap;
            cons_seen  <= cons_hit & ~do_swap;
            if (do_swap) phase <= (phase == PW'(NBUF - 1)) ? '0 : phase + 1'b1;
        end
    end

    // Writer uses the phase; reader trails it by one buffer.
    always_comb begin
        wr_sel = phase;
        rd_sel = (phase == '0) ? PW'(NBUF - 1) : phase - 1'b1;
    end
endmodule

// File: rtl/spm_unit.sv
// Banked scratchpad with interleaved or blocked decode, a vector queue
// mode and a rotating multi-buffer mode. Storage is a flop array, so
// every read lane sees an independent copy. Assumes powers of two for
// LANES, BANKS, BANK_DEPTH and NBUF, BANKS >= LANES, and NBUF dividing
// the total word count.
module spm_unit
    import spm_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int BANKS      = 4,
    parameter int BANK_DEPTH = 16,
    parameter int DW         = 16,
    parameter int NBUF       = 2,
    localparam int BB        = $clog2(BANKS),
    localparam int OW        = $clog2(BANK_DEPTH),
    localparam int AW        = BB + OW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_mode,
    input  logic                     cfg_blocked,
    input  logic                     wr_valid,
    input  logic [LANES-1:0]         wr_mask,
    input  logic [LANES-1:0][AW-1:0] wr_addr,
    input  logic [LANES-1:0][DW-1:0] wr_data,
    output logic                     wr_ready,
    input  logic                     rd_valid,
    input  logic [LANES-1:0][AW-1:0] rd_addr,
    output logic                     rd_ready,
    output logic [LANES-1:0][DW-1:0] rd_data,
    output logic                     rd_data_valid,
    input  logic                     prod_done,
    input  logic                     cons_done,
    output logic                     swap_pulse,
    output logic                     fifo_full,
    output logic                     fifo_empty
);
    localparam int TOTAL     = BANKS * BANK_DEPTH;
    localparam int BUF_WORDS = TOTAL / NBUF;
    localparam int FIFO_VECS = TOTAL / LANES;
    localparam int FPW       = $clog2(FIFO_VECS);
    localparam int NPW       = $clog2(NBUF);

    spm_mode_e mode;
    logic is_fifo, is_nbuf, blk_eff;
    logic push, pop, rd_fire, wr_go;
    logic [FPW-1:0] fifo_wptr, fifo_rptr;
    logic [NPW-1:0] nb_wr_sel, nb_rd_sel;
    logic [LANES-1:0] done_mask, pending, grant;
    logic sched_last;
    logic [LANES-1:0][AW-1:0] wr_phys, rd_phys;
    logic [LANES-1:0][BB-1:0] wr_bank, rd_bank;
    logic [LANES-1:0][OW-1:0] wr_off, rd_off;
    logic [DW-1:0] mem [BANKS][BANK_DEPTH];

    // Mode decode and port-level handshakes.
    always_comb begin
        mode     = spm_mode_e'(cfg_mode);
        is_fifo  = (mode == MODE_FIFO);
        is_nbuf  = (mode == MODE_NBUF);
        blk_eff  = cfg_blocked & ~is_fifo;
        wr_go    = wr_valid & ~(is_fifo & fifo_full);
        push     = wr_valid & is_fifo & ~fifo_full;
        rd_ready = is_fifo ? ~fifo_empty : 1'b1;
        rd_fire  = rd_valid & rd_ready;
        pop      = rd_fire & is_fifo;
        pending  = wr_go ? ((is_fifo ? {LANES{1'b1}} : wr_mask) & ~done_mask) : '0;
        wr_ready = is_fifo ? ~fifo_full : sched_last;
    end

    spm_fifo_ctrl #(.DEPTH(FIFO_VECS)) i_fifo (
        .clk(clk), .rst_n(rst_n), .enable(is_fifo), .push(push), .pop(pop),
        .wptr(fifo_wptr), .rptr(fifo_rptr), .full(fifo_full), .empty(fifo_empty)
    );

    spm_nbuf_ctrl #(.NBUF(NBUF)) i_nbuf (
        .clk(clk), .rst_n(rst_n), .enable(is_nbuf),
        .prod_done(prod_done), .cons_done(cons_done),
        .wr_sel(nb_wr_sel), .rd_sel(nb_rd_sel), .swap_pulse(swap_pulse)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Physical word address per lane, by mode.
        always_comb begin
            if (is_fifo) begin
                wr_phys[l] = AW'(fifo_wptr) * AW'(LANES) + AW'(l);
                rd_phys[l] = AW'(fifo_rptr) * AW'(LANES) + AW'(l);
            end else if (is_nbuf) begin
                wr_phys[l] = AW'(nb_wr_sel) * AW'(BUF_WORDS) + wr_addr[l];
                rd_phys[l] = AW'(nb_rd_sel) * AW'(BUF_WORDS) + rd_addr[l];
            end else begin
                wr_phys[l] = wr_addr[l];
                rd_phys[l] = rd_addr[l];
            end
        end

        spm_addr_decode #(.BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH)) i_wdec (
            .addr(wr_phys[l]), .blocked(blk_eff), .bank(wr_bank[l]), .offset(wr_off[l])
        );
        spm_addr_decode #(.BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH)) i_rdec (
            .addr(rd_phys[l]), .blocked(blk_eff), .bank(rd_bank[l]), .offset(rd_off[l])
        );
    end

    spm_write_sched #(.LANES(LANES), .BB(BB)) i_sched (
        .pending(pending), .bank(wr_bank), .grant(grant), .last(sched_last)
    );

    // Track lanes already committed by a multi-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_mask <= '0;
        end else if (wr_valid && !is_fifo && !sched_last) begin
            done_mask <= done_mask | grant;
        end else begin
            done_mask <= '0;
        end
    end

    // Commit granted lanes; at most one lane per bank each cycle.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (grant[l]) mem[wr_bank[l]][wr_off[l]] <= wr_data[l];
        end
    end

    // Registered read of every lane, each with its own view of the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_valid <= 1'b0;
            rd_data       <= '0;
        end else begin
            rd_data_valid <= rd_fire;
            if (rd_fire) begin
                for (int l = 0; l < LANES; l++) begin
                    rd_data[l] <= mem[rd_bank[l]][rd_off[l]];
                end
            end
        end
    end
endmodule

// File: rtl/spm_unit_checker.sv
// Port-level properties of spm_unit, attached through bind.
module spm_unit_checker
    import spm_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int BANKS      = 4,
    parameter int BANK_DEPTH = 16,
    localparam int BB        = $clog2(BANKS),
    localparam int AW        = BB + $clog2(BANK_DEPTH)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               cfg_mode,
    input logic                     cfg_blocked,
    input logic                     wr_valid,
    input logic [LANES-1:0]         wr_mask,
    input logic [LANES-1:0][AW-1:0] wr_addr,
    input logic                     wr_ready,
    input logic                     rd_valid,
    input logic                     rd_ready,
    input logic                     rd_data_valid,
    input logic                     swap_pulse,
    input logic                     fifo_full,
    input logic                     fifo_empty
);
    localparam logic [AW-1:0] LOW_MASK = AW'(BANKS - 1);
    logic no_clash;

    // Interleaved decode: do enabled lanes fall in distinct banks?
    always_comb begin
        no_clash = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (j < i && wr_mask[i] && wr_mask[j] &&
                    ((wr_addr[i] ^ wr_addr[j]) & LOW_MASK) == '0) begin
                    no_clash = 1'b0;
                end
            end
        end
    end

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
    assert_full_blocks_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_FIFO && fifo_full) |-> !wr_ready);
    assert_empty_blocks_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_FIFO && fifo_empty) |-> !rd_ready);
    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> rd_data_valid);
    assert_no_spurious_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_ready) |=> !rd_data_valid);
    assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cfg_mode != MODE_FIFO && wr_mask == '0) |-> wr_ready);
    assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cfg_mode == MODE_BANKED && !cfg_blocked && no_clash) |-> wr_ready);
    assert_swap_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> ($past(cfg_mode) == MODE_NBUF));
    assert_write_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && cfg_mode != MODE_FIFO) |=> wr_valid);
endmodule

bind spm_unit spm_unit_checker #(
    .LANES(LANES), .BANKS(BANKS), .BANK_DEPTH(BANK_DEPTH)
) i_spm_unit_checker (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_blocked(cfg_blocked),
    .wr_valid(wr_valid), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data_valid(rd_data_valid),
    .swap_pulse(swap_pulse), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/test_spm_unit.sv
// Directed bench for spm_unit: one task per scenario.
module test_spm_unit;
    localparam int LANES = 4, AW = 6, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_blocked = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0;
    logic prod_done = 1'b0, cons_done = 1'b0;
    logic [LANES-1:0] wr_mask = '0;
    logic [LANES-1:0][AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [LANES-1:0][DW-1:0] wr_data = '0, rd_data;
    logic wr_ready, rd_ready, rd_data_valid, swap_pulse, fifo_full, fifo_empty;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spm_unit i_spm_unit (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_blocked(cfg_blocked),
        .wr_valid(wr_valid), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_data_valid(rd_data_valid), .prod_done(prod_done),
        .cons_done(cons_done), .swap_pulse(swap_pulse), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Present a write vector and hold it until accepted; n counts cycles.
    task automatic wr_vec(input logic [LANES-1:0] m, input logic [LANES-1:0][AW-1:0] a,
                          input logic [LANES-1:0][DW-1:0] d, output int n);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_mask = m; wr_addr = a; wr_data = d;
        @(negedge clk); n = 1;
        while (!wr_ready) begin @(negedge clk); n++; end
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    // Present one read cycle; return acceptance, data and the data-valid flag.
    task automatic rd_vec(input logic [LANES-1:0][AW-1:0] a, output logic [LANES-1:0][DW-1:0] q,
                          output logic ok, output logic dv);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk); ok = rd_ready;
        @(posedge clk); #1;
        rd_valid = 1'b0;
        @(negedge clk); q = rd_data; dv = rd_data_valid;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 empty", 64'(fifo_empty), 64'd1);
        chk("R1 full", 64'(fifo_full), 64'd0);
        chk("R1 rd_data_valid", 64'(rd_data_valid), 64'd0);
        chk("R1 swap_pulse", 64'(swap_pulse), 64'd0);
    endtask

    task automatic t_interleaved();
        int n; logic [LANES-1:0][DW-1:0] q; logic ok, dv;
        cfg_mode = 2'd0; cfg_blocked = 1'b0;
        wr_vec(4'hF, {6'd3, 6'd2, 6'd1, 6'd0}, {16'hA003, 16'hA002, 16'hA001, 16'hA000}, n);
        chk("R2 consecutive one cycle", 64'(n), 64'd1);
        wr_vec(4'hF, {6'd19, 6'd14, 6'd9, 6'd4}, {16'hB019, 16'hB014, 16'hB009, 16'hB004}, n);
        chk("R2 strided distinct banks", 64'(n), 64'd1);
        rd_vec({6'd1, 6'd2, 6'd0, 6'd3}, q, ok, dv);
        chk("R5 ready", 64'(ok), 64'd1);
        chk("R5 data valid", 64'(dv), 64'd1);
        chk("R5 permuted read", 64'(q), {16'hA001, 16'hA002, 16'hA000, 16'hA003});
        rd_vec({6'd4, 6'd19, 6'd9, 6'd14}, q, ok, dv);
        chk("R2 readback", 64'(q), {16'hB004, 16'hB019, 16'hB009, 16'hB014});
        @(negedge clk);
        chk("R5 valid one cycle", 64'(rd_data_valid), 64'd0);
    endtask

    task automatic t_blocked();
        int n; logic [LANES-1:0][DW-1:0] q; logic ok, dv;
        cfg_blocked = 1'b1;
        wr_vec(4'hF, {6'd23, 6'd22, 6'd21, 6'd20}, {16'hC023, 16'hC022, 16'hC021, 16'hC020}, n);
        chk("R3 same bank four cycles", 64'(n), 64'd4);
        wr_vec(4'hF, {6'd48, 6'd32, 6'd16, 6'd0}, {16'hC048, 16'hC032, 16'hC016, 16'hC000}, n);
        chk("R3 bank-strided one cycle", 64'(n), 64'd1);
        wr_vec(4'hF, {6'd50, 6'd49, 6'd33, 6'd17}, {16'hC050, 16'hC049, 16'hC033, 16'hC017}, n);
        chk("R3 two per bank two cycles", 64'(n), 64'd2);
        rd_vec({6'd20, 6'd21, 6'd22, 6'd23}, q, ok, dv);
        chk("R3 readback serialised", 64'(q), {16'hC020, 16'hC021, 16'hC022, 16'hC023});
        rd_vec({6'd50, 6'd33, 6'd48, 6'd0}, q, ok, dv);
        chk("R3 readback mixed", 64'(q), {16'hC050, 16'hC033, 16'hC048, 16'hC000});
        cfg_blocked = 1'b0;
    endtask

    task automatic t_lane_order();
        int n; logic [LANES-1:0][DW-1:0] q; logic ok, dv;
        wr_vec(4'hF, {6'd10, 6'd10, 6'd10, 6'd10}, {16'hD003, 16'hD002, 16'hD001, 16'hD000}, n);
        chk("R4 conflict cycles", 64'(n), 64'd4);
        rd_vec({6'd10, 6'd10, 6'd10, 6'd10}, q, ok, dv);
        chk("R4 highest lane kept, R5 shared word", 64'(q), {4{16'hD003}});
        wr_vec(4'b0110, {6'd10, 6'd11, 6'd11, 6'd10}, {16'hE003, 16'hE002, 16'hE001, 16'hE000}, n);
        rd_vec({6'd11, 6'd10, 6'd11, 6'd10}, q, ok, dv);
        chk("R4 masked conflict", 64'(q), {16'hE002, 16'hD003, 16'hE002, 16'hD003});
    endtask

    task automatic t_mask();
        int n; logic [LANES-1:0][DW-1:0] q; logic ok, dv;
        wr_vec(4'hF, {6'd33, 6'd32, 6'd31, 6'd30}, {16'h1003, 16'h1002, 16'h1001, 16'h1000}, n);
        wr_vec(4'b1010, {6'd33, 6'd32, 6'd31, 6'd30}, {16'h2003, 16'h2002, 16'h2001, 16'h2000}, n);
        rd_vec({6'd33, 6'd32, 6'd31, 6'd30}, q, ok, dv);
        chk("R6 partial mask", 64'(q), {16'h2003, 16'h1002, 16'h2001, 16'h1000});
        wr_vec(4'h0, {6'd33, 6'd32, 6'd31, 6'd30}, {4{16'hFFFF}}, n);
        chk("R6 empty mask one cycle", 64'(n), 64'd1);
        rd_vec({6'd33, 6'd32, 6'd31, 6'd30}, q, ok, dv);
        chk("R6 empty mask no write", 64'(q), {16'h2003, 16'h1002, 16'h2001, 16'h1000});
    endtask

    task automatic t_same_cycle();
        logic [LANES-1:0][DW-1:0] q; logic ok, dv; int n;
        wr_vec(4'b0001, {4{6'd40}}, {4{16'h4040}}, n);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_mask = 4'b0001; wr_addr = {4{6'd40}}; wr_data = {4{16'h5151}};
        rd_valid = 1'b1; rd_addr = {4{6'd40}};
        @(posedge clk); #1;
        wr_valid = 1'b0; rd_valid = 1'b0;
        @(negedge clk);
        chk("R12 old value on collision", 64'(rd_data[0]), 64'h4040);
        rd_vec({4{6'd40}}, q, ok, dv);
        chk("R12 new value afterwards", 64'(q[2]), 64'h5151);
    endtask

    task automatic t_fifo();
        int n; logic [LANES-1:0][DW-1:0] q, exp; logic ok, dv;
        @(posedge clk); #1; cfg_mode = 2'd1; cfg_blocked = 1'b1;
        @(negedge clk);
        chk("R8 empty on entry", 64'(fifo_empty), 64'd1);
        chk("R8 pop blocked when empty", 64'(rd_ready), 64'd0);
        rd_vec({4{6'd7}}, q, ok, dv);
        chk("R8 no data when empty", 64'(dv), 64'd0);
        for (int v = 0; v < 16; v++) begin
            for (int l = 0; l < LANES; l++) exp[l] = 16'(16'h0300 + v * 4 + l);
            wr_vec(4'h0, {4{6'(v)}}, exp, n);
        end
        @(negedge clk);
        chk("R8 full after capacity", 64'(fifo_full), 64'd1);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_data = {4{16'hDEAD}};
        @(negedge clk);
        chk("R8 push blocked when full", 64'(wr_ready), 64'd0);
        @(posedge clk); #1; wr_valid = 1'b0;
        for (int v = 0; v < 16; v++) begin
            for (int l = 0; l < LANES; l++) exp[l] = 16'(16'h0300 + v * 4 + l);
            rd_vec({4{6'(63 - v)}}, q, ok, dv);
            chk("R7 pop order", 64'(q), 64'(exp));
        end
        @(negedge clk);
        chk("R8 empty after drain", 64'(fifo_empty), 64'd1);
        @(posedge clk); #1; cfg_mode = 2'd0; cfg_blocked = 1'b0;
    endtask

    // Pulse done inputs for one cycle; report swap_pulse one edge later.
    task automatic pulse_done(input logic p, input logic c, output logic got);
        @(posedge clk); #1; prod_done = p; cons_done = c;
        @(posedge clk); #1; prod_done = 1'b0; cons_done = 1'b0;
        @(negedge clk); got = swap_pulse;
    endtask

    task automatic t_nbuf();
        int n; logic [LANES-1:0][DW-1:0] q; logic ok, dv, got;
        wr_vec(4'b0001, {4{6'd37}}, {4{16'h7777}}, n);
        @(posedge clk); #1; cfg_mode = 2'd2;
        wr_vec(4'b0001, {4{6'd5}}, {4{16'h8888}}, n);
        rd_vec({4{6'd5}}, q, ok, dv);
        chk("R9 reader on other buffer", 64'(q[0]), 64'h7777);
        pulse_done(1'b1, 1'b0, got);
        chk("R10 producer alone no swap", 64'(got), 64'd0);
        repeat (2) @(negedge clk);
        chk("R10 still no swap", 64'(swap_pulse), 64'd0);
        rd_vec({4{6'd5}}, q, ok, dv);
        chk("R10 reader unchanged", 64'(q[0]), 64'h7777);
        pulse_done(1'b0, 1'b1, got);
        chk("R10 swap after both", 64'(got), 64'd1);
        @(negedge clk);
        chk("R10 pulse one cycle", 64'(swap_pulse), 64'd0);
        rd_vec({4{6'd5}}, q, ok, dv);
        chk("R9 reader sees filled buffer", 64'(q[0]), 64'h8888);
        wr_vec(4'b0001, {4{6'd5}}, {4{16'h9999}}, n);
        pulse_done(1'b1, 1'b1, got);
        chk("R10 same-cycle dones swap", 64'(got), 64'd1);
        rd_vec({4{6'd5}}, q, ok, dv);
        chk("R11 phase wraps", 64'(q[0]), 64'h9999);
        pulse_done(1'b0, 1'b1, got);
        chk("R10 flags cleared after swap", 64'(got), 64'd0);
        pulse_done(1'b1, 1'b0, got);
        chk("R10 late producer swaps", 64'(got), 64'd1);
        @(posedge clk); #1; cfg_mode = 2'd0;
        rd_vec({4{6'd37}}, q, ok, dv);
        chk("R9 buffer one holds second fill", 64'(q[1]), 64'h9999);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_interleaved();
        t_blocked();
        t_lane_order();
        t_mask();
        t_same_cycle();
        t_fifo();
        t_nbuf();
        repeat (2) @(posedge clk);
        summary();
    end
endmodule